// File: doc/BRIEF.md
# Dual-Slope Converter Sequencer and Readout

This block is the digital half of a dual-slope integrating voltage converter. It steps through three phases over and over. It zeroes with all analog switches open. It then integrates the unknown input for a fixed number of clocks. Last, it applies a reference of opposite polarity and counts clocks in decimal until the external comparator reports that the integrator is back at zero. The integrator, the comparator and the references are analog parts outside the block. The comparator output is taken to be synchronous to the block clock.

The count from the last phase is the reading. It is shown on three full seven-segment digits plus a leading half digit. The half digit can show only a "1", a minus sign, or both. All drives are active low, for common-anode displays. A decimal point marks the selected full-scale range. The reading, sign, range and overrange state are captured only when a conversion ends, so the display holds steady while the next conversion runs. A conversion that runs past the full count stops and shows the overrange pattern.

Top module: `dsadc_seq`

## Requirements
- R1: While `rst_n` is low, and until the first conversion ends, all three switch enables are low and `overrange` is low. The display shows 000 on the full digits, with the half digit dark and the decimal point on the hundreds digit.
- R2: The internal reset releases on the second rising clock edge after `rst_n` goes high. An auto-zero phase of `AZ_CYCLES` clocks, with all switch enables low, follows the reset and follows the end of every de-integrate phase.
- R3: After each auto-zero phase, `sw_in_en` is high for exactly `INT_CYCLES` clocks while both reference enables stay low.
- R4: `pol_neg_i` is sampled on the last integrate clock. During de-integration exactly one reference enable is high: `sw_refp_en` if that sample was 1 (negative input), and `sw_refn_en` if it was 0. Later changes of `pol_neg_i` within the conversion have no effect.
- R5: De-integration ends on the first clock at which `comp_i` is high. The reading is the number of earlier de-integrate clocks with `comp_i` low, counted in decimal.
- R6: If `comp_i` is still low on the clock at which the count is already 1999, de-integration ends with overrange. `overrange` goes high. The half digit shows "1". All full-digit segments and all decimal points are dark (all ones). A normal ending clears `overrange`.
- R7: Every display output and `overrange` change only on the clock that ends a de-integrate phase.
- R8: `seg_n[7*d+s]` drives segment s of full digit d. Here d=0 is units, d=1 tens, d=2 hundreds, and s=0..6 are segments a..g. A segment is lit when its bit is 0. Digits 0..9 light the patterns gfedcba = 3F,06,5B,4F,66,6D,7D,07,7F,6F (hex). Leading zeros are shown.
- R9: `lead_one_n` is low when the captured reading is 1000 or more, or on overrange. `lead_minus_n` is low when the captured polarity sample (R4) was 1.
- R10: `range_i` is sampled on the clock that ends de-integration. A sample of 0 lights `dp_n[2]` (hundreds digit, 20 V scale) and a sample of 1 lights `dp_n[1]` (tens digit, 200 V scale). All other points stay dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_i | input | 1 | Comparator: high once the integrator has crossed zero |
| pol_neg_i | input | 1 | Input polarity, 1 = negative |
| range_i | input | 1 | Range select, 0 = 20 V scale, 1 = 200 V scale |
| sw_in_en | output | 1 | Connects the unknown input to the integrator |
| sw_refp_en | output | 1 | Connects the positive reference |
| sw_refn_en | output | 1 | Connects the negative reference |
| seg_n | output | 7*NFULL | Full-digit segments, active low |
| dp_n | output | NFULL | Decimal points, one per full digit, active low |
| lead_one_n | output | 1 | Half digit "1" segments, active low |
| lead_minus_n | output | 1 | Half digit minus sign, active low |
| overrange | output | 1 | Last conversion exceeded full scale |

## Verification
The bench drives the comparator high at chosen counts. These are 0, 1, 9, 10, 999, 1000 and 1999, which hit every decimal carry and the leading-one threshold, plus targets that never arrive. An off-by-one in the stop rule would show as a reading one higher than the target, or as overrange reported at 1999 instead of 2000. A counter that carried wrongly would show a wrong digit such as 9 turning into A. Polarity and range are toggled outside their sampling clocks. A design that latched them at the wrong time would drive the wrong reference, or move the sign or decimal point in the middle of a conversion. A reset in the middle of integration checks that the sequence and the display restart cleanly.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_t;

  // Active-high segment pattern, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] seg7_on(input logic [3:0] d);
    logic [6:0] p;
    case (d)
      4'd0:    p = 7'h3F;
      4'd1:    p = 7'h06;
      4'd2:    p = 7'h5B;
      4'd3:    p = 7'h4F;
      4'd4:    p = 7'h66;
      4'd5:    p = 7'h6D;
      4'd6:    p = 7'h7D;
      4'd7:    p = 7'h07;
      4'd8:    p = 7'h7F;
      4'd9:    p = 7'h6F;
      default: p = 7'h00;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
  import dsadc_pkg::*;
#(
  parameter int AZ_CYCLES  = 1000,
  parameter int INT_CYCLES = 1000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   comp_i,
  input  logic   pol_neg_i,
  input  logic   cnt_full_i,
  output phase_t phase_o,
  output logic   ref_pos_o,
  output logic   clr_o,
  output logic   inc_o,
  output logic   done_o,
  output logic   over_o
);

  localparam int LONGEST = (AZ_CYCLES > INT_CYCLES) ? AZ_CYCLES : INT_CYCLES;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] AZ_LAST  = CW'(AZ_CYCLES - 1);
  localparam logic [CW-1:0] INT_LAST = CW'(INT_CYCLES - 1);

  phase_t        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          refpos_q, refpos_d;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    refpos_d = refpos_q;
    clr_o    = 1'b0;
    inc_o    = 1'b0;
    done_o   = 1'b0;
    over_o   = 1'b0;
    case (phase_q)
      PH_AZ: begin
        if (cnt_q == AZ_LAST) begin
          phase_d = PH_INT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_INT: begin
        if (cnt_q == INT_LAST) begin
          phase_d  = PH_DEINT;
          cnt_d    = '0;
          refpos_d = pol_neg_i;
          clr_o    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DEINT: begin
        if (comp_i) begin
          done_o  = 1'b1;
          phase_d = PH_AZ;
        end else if (cnt_full_i) begin
          done_o  = 1'b1;
          over_o  = 1'b1;
          phase_d = PH_AZ;
        end else begin
          inc_o = 1'b1;
        end
      end
      default: begin
        phase_d = PH_AZ;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_AZ;
      cnt_q    <= '0;
      refpos_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      refpos_q <= refpos_d;
    end
  end

  assign phase_o   = phase_q;
  assign ref_pos_o = refpos_q;

endmodule

// File: rtl/dsadc_bcd_count.sv
module dsadc_bcd_count #(
  parameter int NFULL = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic [NFULL-1:0][3:0] digit_o,
  output logic                  lead_o,
  output logic                  full_o
);

  logic [NFULL:0]   carry;
  logic [NFULL-1:0] nine;
  logic             lead_q, lead_d;

  assign carry[0] = inc_i;

  for (genvar i = 0; i < NFULL; i++) begin : g_dig
    logic [3:0] d_q, d_d;

    assign nine[i]      = (d_q == 4'd9);
    assign carry[i+1]   = carry[i] && nine[i];
    assign digit_o[i]   = d_q;

    always_comb begin
      if (clr_i)         d_d = 4'd0;
      else if (carry[i]) d_d = nine[i] ? 4'd0 : d_q + 4'd1;
      else               d_d = d_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q <= 4'd0;
      else        d_q <= d_d;
    end
  end

  always_comb begin
    if (clr_i)             lead_d = 1'b0;
    else if (carry[NFULL]) lead_d = 1'b1;
    else                   lead_d = lead_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lead_q <= 1'b0;
    else        lead_q <= lead_d;
  end

  assign lead_o = lead_q;
  assign full_o = lead_q && (&nine);

endmodule

// File: rtl/dsadc_readout.sv
module dsadc_readout
  import dsadc_pkg::*;
#(
  parameter int NFULL = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  over_i,
  input  logic                  neg_i,
  input  logic                  range_i,
  input  logic [NFULL-1:0][3:0] digit_i,
  input  logic                  lead_i,
  output logic [7*NFULL-1:0]    seg_n_o,
  output logic [NFULL-1:0]      dp_n_o,
  output logic                  lead_one_n_o,
  output logic                  lead_minus_n_o,
  output logic                  over_o
);

  localparam int DP_LO_RANGE = NFULL - 1;
  localparam int DP_HI_RANGE = NFULL - 2;

  logic [NFULL-1:0][3:0] digit_q, digit_d;
  logic                  lead_q, lead_d;
  logic                  neg_q, neg_d;
  logic                  rng_q, rng_d;
  logic                  over_q, over_d;

  always_comb begin
    digit_d = digit_q;
    lead_d  = lead_q;
    neg_d   = neg_q;
    rng_d   = rng_q;
    over_d  = over_q;
    if (load_i) begin
      digit_d = digit_i;
      lead_d  = lead_i;
      neg_d   = neg_i;
      rng_d   = range_i;
      over_d  = over_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digit_q <= '0;
      lead_q  <= 1'b0;
      neg_q   <= 1'b0;
      rng_q   <= 1'b0;
      over_q  <= 1'b0;
    end else begin
      digit_q <= digit_d;
      lead_q  <= lead_d;
      neg_q   <= neg_d;
      rng_q   <= rng_d;
      over_q  <= over_d;
    end
  end

  for (genvar i = 0; i < NFULL; i++) begin : g_out
    assign seg_n_o[7*i +: 7] = over_q ? 7'h7F : ~seg7_on(digit_q[i]);
    assign dp_n_o[i] = over_q ||
                       (rng_q ? (i != DP_HI_RANGE) : (i != DP_LO_RANGE));
  end

  assign lead_one_n_o   = !(lead_q || over_q);
  assign lead_minus_n_o = !neg_q;
  assign over_o         = over_q;

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int AZ_CYCLES  = 1000,
  parameter int INT_CYCLES = 1000,
  parameter int NFULL      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               comp_i,
  input  logic               pol_neg_i,
  input  logic               range_i,
  output logic               sw_in_en,
  output logic               sw_refp_en,
  output logic               sw_refn_en,
  output logic [7*NFULL-1:0] seg_n,
  output logic [NFULL-1:0]   dp_n,
  output logic               lead_one_n,
  output logic               lead_minus_n,
  output logic               overrange
);

  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  phase_t                phase;
  logic                  ref_pos, cnt_clr, cnt_inc, conv_done, conv_over;
  logic                  cnt_full, cnt_lead;
  logic [NFULL-1:0][3:0] cnt_digit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dsadc_phase_ctrl #(
    .AZ_CYCLES (AZ_CYCLES),
    .INT_CYCLES(INT_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .comp_i    (comp_i),
    .pol_neg_i (pol_neg_i),
    .cnt_full_i(cnt_full),
    .phase_o   (phase),
    .ref_pos_o (ref_pos),
    .clr_o     (cnt_clr),
    .inc_o     (cnt_inc),
    .done_o    (conv_done),
    .over_o    (conv_over)
  );

  dsadc_bcd_count #(.NFULL(NFULL)) u_count (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .digit_o(cnt_digit),
    .lead_o (cnt_lead),
    .full_o (cnt_full)
  );

  dsadc_readout #(.NFULL(NFULL)) u_disp (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .load_i        (conv_done),
    .over_i        (conv_over),
    .neg_i         (ref_pos),
    .range_i       (range_i),
    .digit_i       (cnt_digit),
    .lead_i        (cnt_lead),
    .seg_n_o       (seg_n),
    .dp_n_o        (dp_n),
    .lead_one_n_o  (lead_one_n),
    .lead_minus_n_o(lead_minus_n),
    .over_o        (overrange)
  );

  assign sw_in_en   = (phase == PH_INT);
  assign sw_refp_en = (phase == PH_DEINT) &&  ref_pos;
  assign sw_refn_en = (phase == PH_DEINT) && !ref_pos;

endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int AZ_CYCLES  = 1000,
  parameter int INT_CYCLES = 1000,
  parameter int NSEG       = 21,
  parameter int NDP        = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            comp_i,
  input logic            sw_in_en,
  input logic            sw_refp_en,
  input logic            sw_refn_en,
  input logic [NSEG-1:0] seg_n,
  input logic [NDP-1:0]  dp_n,
  input logic            lead_one_n,
  input logic            lead_minus_n,
  input logic            overrange
);

  logic        ref_on;
  logic [31:0] in_run, off_run;

  assign ref_on = sw_refp_en || sw_refn_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_run  <= '0;
      off_run <= '0;
    end else begin
      in_run  <= sw_in_en ? in_run + 1 : '0;
      off_run <= (!sw_in_en && !ref_on) ? off_run + 1 : '0;
    end
  end

  assert_sw_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_in_en, sw_refp_en, sw_refn_en}));

  assert_ref_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_in_en) |-> ref_on);

  assert_int_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_in_en) |-> (in_run == INT_CYCLES));

  assert_az_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_in_en) |-> (off_run == AZ_CYCLES));

  assert_stop_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_on && comp_i) |=> !ref_on);

  assert_disp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_on |=> $stable({seg_n, dp_n, lead_one_n, lead_minus_n, overrange}));

  assert_over_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrange |-> ((&seg_n) && (&dp_n) && !lead_one_n));

endmodule

bind dsadc_seq dsadc_seq_chk #(
  .AZ_CYCLES (AZ_CYCLES),
  .INT_CYCLES(INT_CYCLES),
  .NSEG      (7*NFULL),
  .NDP       (NFULL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .comp_i      (comp_i),
  .sw_in_en    (sw_in_en),
  .sw_refp_en  (sw_refp_en),
  .sw_refn_en  (sw_refn_en),
  .seg_n       (seg_n),
  .dp_n        (dp_n),
  .lead_one_n  (lead_one_n),
  .lead_minus_n(lead_minus_n),
  .overrange   (overrange)
);

// File: tb/sim_dsadc_seq.sv
`timescale 1ns/1ps
module sim_dsadc_seq;

  localparam int AZ  = 1000;
  localparam int INTG = 1000;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        comp_i = 1'b0;
  logic        pol_neg_i = 1'b0;
  logic        range_i = 1'b0;
  logic        sw_in_en, sw_refp_en, sw_refn_en;
  logic [20:0] seg_n;
  logic [2:0]  dp_n;
  logic        lead_one_n, lead_minus_n, overrange;

  int vectors = 0;
  int misses  = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  dsadc_seq #(.AZ_CYCLES(AZ), .INT_CYCLES(INTG), .NFULL(3)) u0 (
    .clk(clk), .rst_n(rst_n), .comp_i(comp_i), .pol_neg_i(pol_neg_i),
    .range_i(range_i), .sw_in_en(sw_in_en), .sw_refp_en(sw_refp_en),
    .sw_refn_en(sw_refn_en), .seg_n(seg_n), .dp_n(dp_n),
    .lead_one_n(lead_one_n), .lead_minus_n(lead_minus_n),
    .overrange(overrange)
  );

  // ---------------- behavioural reference ----------------
  int m_rel, m_ph, m_cnt, m_bcd;
  bit m_pol;
  int m_val;
  bit m_neg, m_rng, m_over;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_ph = 0; m_cnt = 0; m_bcd = 0; m_pol = 0;
      m_val = 0; m_neg = 0; m_rng = 0; m_over = 0;
    end else begin
      if (m_rel == 2) begin
        if (m_ph == 0) begin
          if (m_cnt == AZ - 1) begin m_ph = 1; m_cnt = 0; end
          else m_cnt++;
        end else if (m_ph == 1) begin
          if (m_cnt == INTG - 1) begin
            m_ph = 2; m_cnt = 0; m_bcd = 0; m_pol = pol_neg_i;
          end else m_cnt++;
        end else begin
          if (comp_i || m_bcd == 1999) begin
            m_over = !comp_i;
            m_val  = m_bcd;
            m_neg  = m_pol;
            m_rng  = range_i;
            m_ph   = 0;
          end else m_bcd++;
        end
      end
      if (m_rel < 2) m_rel++;
    end
  end

  function automatic logic [6:0] glyph(int d);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return t[d];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [20:0] e_seg;
    logic [2:0]  e_dp;
    for (int i = 0; i < 3; i++) begin
      int dig;
      dig = (m_val / (10 ** i)) % 10;
      e_seg[7*i +: 7] = m_over ? 7'h7F : ~glyph(dig);
      e_dp[i] = m_over || (i != (m_rng ? 1 : 2));
    end
    chk("R2 R3 sw_in_en", 32'(sw_in_en), 32'(m_ph == 1));
    chk("R4 sw_refp_en", 32'(sw_refp_en), 32'(m_ph == 2 && m_pol));
    chk("R4 sw_refn_en", 32'(sw_refn_en), 32'(m_ph == 2 && !m_pol));
    chk("R5 R6 R7 R8 seg_n", 32'(seg_n), 32'(e_seg));
    chk("R10 dp_n", 32'(dp_n), 32'(e_dp));
    chk("R9 lead_one_n", 32'(lead_one_n), 32'(!(m_over || m_val >= 1000)));
    chk("R9 lead_minus_n", 32'(lead_minus_n), 32'(!m_neg));
    chk("R6 overrange", 32'(overrange), 32'(m_over));
  endtask

  int  tgt;
  bit  tpol, trng;

  task automatic tick();
    @(negedge clk);
    compare_all();
    comp_i    = (m_ph == 2) && (m_bcd >= tgt);
    pol_neg_i = (m_ph == 1) ? tpol : !tpol;
    range_i   = (m_ph == 2) ? trng : !trng;
  endtask

  task automatic run_conv(int target, bit pol, bit rng);
    bit seen;
    seen = 0;
    tgt = target; tpol = pol; trng = rng;
    while (!(seen && m_ph == 0)) begin
      tick();
      if (m_ph == 2) seen = 1;
    end
  endtask

  task automatic check_reset_state();
    chk("R1 sw_in_en", 32'(sw_in_en), 32'd0);
    chk("R1 refs", 32'({sw_refp_en, sw_refn_en}), 32'd0);
    chk("R1 seg_n", 32'(seg_n), 32'({3{7'h40}}));
    chk("R1 dp_n", 32'(dp_n), 32'(3'b011));
    chk("R1 lead", 32'({lead_one_n, lead_minus_n}), 32'(2'b11));
    chk("R1 overrange", 32'(overrange), 32'd0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #(WATCHDOG_CYCLES * 5.0);
    misses++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    tgt = 5000; tpol = 0; trng = 0;
    repeat (3) @(negedge clk);
    check_reset_state();             // R1 under reset
    rst_n = 1'b1;
    repeat (5) tick();
    check_reset_state();             // R1 after release, before first result
    run_conv(0,    0, 0);            // R5 immediate zero
    run_conv(1,    1, 1);            // R4 positive reference, R9 sign
    run_conv(9,    0, 1);
    run_conv(10,   1, 0);            // R8 carry into tens
    run_conv(999,  0, 0);
    run_conv(1000, 1, 1);            // R9 leading one threshold
    run_conv(1234, 1, 0);
    run_conv(1999, 0, 1);            // R6 boundary: still valid
    run_conv(2000, 1, 0);            // R6 overrange
    run_conv(3000, 0, 1);            // R6 overrange, other range
    run_conv(57,   1, 1);            // R6 cleared by normal end
    // reset in the middle of integration
    tgt = 40; tpol = 0; trng = 1;
    while (m_ph != 1) tick();
    repeat (100) tick();
    rst_n = 1'b0;
    repeat (3) tick();
    check_reset_state();             // R1 after mid-run reset
    rst_n = 1'b1;
    run_conv(40,   0, 1);            // R2 restart sequence
    repeat (20) tick();
    finish_run();
  end

endmodule